// File: doc/BRIEF.md
# Dual-Bank Asynchronous SRAM Controller

This block is a clocked controller for an external asynchronous static memory made of two 64K x 16 banks. The banks share the data bus, the lower fifteen address lines, one active-low write strobe and one active-low output enable. Each bank has its own active-low chip select and its own upper address line. A host issues single-word requests over a request/acknowledge port. Each request carries a 17-bit word address, a write flag and 16 bits of write data. The controller turns each request into a strobe sequence on the memory pins.

Every phase of an access lasts a whole number of clock cycles. The length of each phase comes from a minimum time in picoseconds divided by the clock period, rounded up, and is never less than one cycle. The data bus leaves the controller as separate output, output-enable and input vectors, so a pad ring can build the tri-state driver. With the default 10 ns clock a write takes three cycles from acceptance to acknowledge. A read takes the same three cycles and then one idle turnaround cycle.

Top module: `sram2b_ctrl`

## Requirements
- R1: While reset is held and after its release with no request, both chip selects, the write strobe and the output enable are high. Both upper address lines are low, the data drive enable is low and the acknowledge is low.
- R2: Host address bit 16 equal to 0 selects bank A. During the access `mem_ce_a_n` is low and `mem_a15_a` equals address bit 15. `mem_ce_b_n` stays high and `mem_a15_b` stays low. A bank's upper address line is low whenever that bank's chip select is high.
- R3: Host address bit 16 equal to 1 selects bank B, with the roles of the two banks swapped. A word written to one bank does not change the word at the same low address in the other bank.
- R4: Write sequence. In the first cycle after acceptance (setup) the chip select is low, while the write strobe and output enable are high and the bus is not driven. In the second cycle (strobe) the write strobe is low, the drive enable is high and the output enable stays high. After that cycle the strobe rises and the drive is released.
- R5: Read sequence. The setup cycle has the output enable high. The strobe cycle has the output enable low and the write strobe high. `rd_data` takes the bus value present at the clock edge that ends the strobe cycle, and changes at no other time.
- R6: `ack` is high for exactly one cycle, the cycle after the strobe cycle. For a read, `rd_data` already holds the captured word in that cycle.
- R7: The bus is driven only while the write strobe is low. The output enable and write strobe are never low together, and the drive enable is never high while the output enable is low.
- R8: After a read there is one turnaround cycle in which both chip selects are high. A request held during the acknowledge cycle and the turnaround cycle is accepted only at the end of the turnaround cycle. After a write, a request presented in the acknowledge cycle is accepted at once.
- R9: A request presented while an access is in progress is ignored. It produces no chip select, no strobe and no change to memory.
- R10: `mem_addr` equals host address bits 14..0 throughout the setup and strobe cycles.
- R11: The strobe cycle of a write drives all 16 bits of the request's write data on `mem_dq_o`, for all-zero, all-one and mixed patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, sampled only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address; bit 16 picks the bank |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read |
| mem_addr | output | 15 | Shared low address lines |
| mem_a15_a | output | 1 | Upper address line, bank A |
| mem_a15_b | output | 1 | Upper address line, bank B |
| mem_ce_a_n | output | 1 | Chip select, bank A, active low |
| mem_ce_b_n | output | 1 | Chip select, bank B, active low |
| mem_we_n | output | 1 | Shared write strobe, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
Two cases are hard to reach from the ports. The first is a request that arrives while the controller is busy. The stimulus keeps `req` high, carrying a different bank and address, through the setup and strobe cycles of a write, and drops it just before the controller returns to idle. A later read of that address shows the memory was left alone. The second is the turnaround after a read. The stimulus raises a write request in the read's acknowledge cycle and holds it, and the bench checks that the chip selects stay high for one more cycle before the write's setup cycle appears. The bench memory model returns a marker value whenever the memory is not enabled, so a read captured in the wrong cycle shows up as a miscompare.

// File: rtl/sram2b_pkg.sv
package sram2b_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_TURN   = 2'd3
  } phase_e;

  // Whole clock cycles that cover a time, never fewer than one.
  function automatic int cycles_for(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram2b_timer.sv
module sram2b_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram2b_bank_decode.sv
module sram2b_bank_decode #(
  parameter int NUM_BANKS = 2,
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 active,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 upper,
  output logic [NUM_BANKS-1:0] ce_n,
  output logic [NUM_BANKS-1:0] upper_o
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit        = active && (sel == SEL_W'(b));
    assign ce_n[b]    = !hit;
    assign upper_o[b] = hit && upper;
  end

endmodule

// File: rtl/sram2b_seq.sv
module sram2b_seq
  import sram2b_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 1,
  parameter int WR_CYC    = 1,
  parameter int TURN_CYC  = 1,
  parameter int CNT_W     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  output logic accept,
  output logic in_setup,
  output logic in_strobe,
  output logic finish
);

  phase_e           st_q;
  phase_e           st_d;
  logic             tm_load;
  logic [CNT_W-1:0] tm_val;
  logic             tm_zero;

  sram2b_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .zero     (tm_zero)
  );

  always_comb begin
    st_d    = st_q;
    tm_load = 1'b0;
    tm_val  = '0;
    case (st_q)
      PH_IDLE: begin
        if (req) begin
          st_d    = PH_SETUP;
          tm_load = 1'b1;
          tm_val  = CNT_W'(SETUP_CYC - 1);
        end
      end
      PH_SETUP: begin
        if (tm_zero) begin
          st_d    = PH_STROBE;
          tm_load = 1'b1;
          tm_val  = wr ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
      end
      PH_STROBE: begin
        if (tm_zero) begin
          if (wr) begin
            st_d = PH_IDLE;
          end else begin
            st_d    = PH_TURN;
            tm_load = 1'b1;
            tm_val  = CNT_W'(TURN_CYC - 1);
          end
        end
      end
      PH_TURN: begin
        if (tm_zero) st_d = PH_IDLE;
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign accept    = (st_q == PH_IDLE) && req;
  assign in_setup  = (st_q == PH_SETUP);
  assign in_strobe = (st_q == PH_STROBE);
  assign finish    = (st_q == PH_STROBE) && tm_zero;

endmodule

// File: rtl/sram2b_ctrl.sv
module sram2b_ctrl
  import sram2b_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 16,
  parameter int CLK_PS     = 10000,
  parameter int T_SETUP_PS = 10000,
  parameter int T_RD_PS    = 10000,
  parameter int T_WR_PS    = 8000,
  parameter int T_TURN_PS  = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-3:0] mem_addr,
  output logic              mem_a15_a,
  output logic              mem_a15_b,
  output logic              mem_ce_a_n,
  output logic              mem_ce_b_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int NUM_BANKS = 2;
  localparam int SEL_W     = 1;
  localparam int SETUP_CYC = cycles_for(T_SETUP_PS, CLK_PS);
  localparam int RD_CYC    = cycles_for(T_RD_PS, CLK_PS);
  localparam int WR_CYC    = cycles_for(T_WR_PS, CLK_PS);
  localparam int TURN_CYC  = cycles_for(T_TURN_PS, CLK_PS);
  localparam int MAX_CYC   = imax(imax(SETUP_CYC, RD_CYC), imax(WR_CYC, TURN_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic              accept;
  logic              in_setup;
  logic              in_strobe;
  logic              finish;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ack_q;
  logic              cap_en;
  logic [NUM_BANKS-1:0] ce_n_vec;
  logic [NUM_BANKS-1:0] upper_vec;

  sram2b_seq #(
    .SETUP_CYC (SETUP_CYC),
    .RD_CYC    (RD_CYC),
    .WR_CYC    (WR_CYC),
    .TURN_CYC  (TURN_CYC),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .wr        (wr_q),
    .accept    (accept),
    .in_setup  (in_setup),
    .in_strobe (in_strobe),
    .finish    (finish)
  );

  // Request holding registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wr_q    <= req_wr;
      wdata_q <= req_wdata;
    end
  end

  assign cap_en = finish && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= mem_dq_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
    end else begin
      ack_q <= finish;
    end
  end

  sram2b_bank_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .active  (in_setup || in_strobe),
    .sel     (addr_q[ADDR_W-1 -: SEL_W]),
    .upper   (addr_q[ADDR_W-2]),
    .ce_n    (ce_n_vec),
    .upper_o (upper_vec)
  );

  assign mem_ce_a_n = ce_n_vec[0];
  assign mem_ce_b_n = ce_n_vec[1];
  assign mem_a15_a  = upper_vec[0];
  assign mem_a15_b  = upper_vec[1];
  assign mem_addr   = addr_q[ADDR_W-3:0];
  assign mem_we_n   = !(in_strobe && wr_q);
  assign mem_oe_n   = !(in_strobe && !wr_q);
  assign mem_dq_oe  = in_strobe && wr_q;
  assign mem_dq_o   = wdata_q;
  assign ack        = ack_q;
  assign rd_data    = rdata_q;

endmodule

// File: rtl/sram2b_ctrl_chk.sv
module sram2b_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [DATA_W-1:0] rd_data,
  input logic              mem_ce_a_n,
  input logic              mem_ce_b_n,
  input logic              mem_a15_a,
  input logic              mem_a15_b,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!mem_ce_a_n, !mem_ce_b_n}) <= 1);

  p_upper_idle_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_a_n |-> !mem_a15_a);

  p_upper_idle_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_b_n |-> !mem_a15_b);

  p_we_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_a_n || !mem_ce_b_n));

  p_rdata_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> ack);

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_drive_in_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  p_strobe_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |=> mem_we_n);

endmodule

bind sram2b_ctrl sram2b_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack        (ack),
  .rd_data    (rd_data),
  .mem_ce_a_n (mem_ce_a_n),
  .mem_ce_b_n (mem_ce_b_n),
  .mem_a15_a  (mem_a15_a),
  .mem_a15_b  (mem_a15_b),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram2b_ctrl_tb.sv
module sram2b_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        req_wr;
  logic [16:0] req_addr;
  logic [15:0] req_wdata;
  logic        ack;
  logic [15:0] rd_data;
  logic [14:0] mem_addr;
  logic        mem_a15_a, mem_a15_b, mem_ce_a_n, mem_ce_b_n;
  logic        mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i;

  int n_chk;
  int n_bad;
  bit done;

  logic [15:0] bank_a [512];
  logic [15:0] bank_b [512];

  sram2b_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_a15_a(mem_a15_a), .mem_a15_b(mem_a15_b),
    .mem_ce_a_n(mem_ce_a_n), .mem_ce_b_n(mem_ce_b_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  initial clk = 1'b0;
  always #5 clk = !clk;

  // Memory model: returns a marker when not enabled for reading
  always_comb begin
    mem_dq_i = 16'hBAD0;
    if (!mem_oe_n && mem_we_n) begin
      if (!mem_ce_a_n && mem_ce_b_n)
        mem_dq_i = bank_a[{mem_a15_a, mem_addr[7:0]}];
      else if (!mem_ce_b_n && mem_ce_a_n)
        mem_dq_i = bank_b[{mem_a15_b, mem_addr[7:0]}];
    end
  end

  always @(posedge clk) begin
    if (!mem_we_n && mem_dq_oe) begin
      if (!mem_ce_a_n) bank_a[{mem_a15_a, mem_addr[7:0]}] <= mem_dq_o;
      if (!mem_ce_b_n) bank_b[{mem_a15_b, mem_addr[7:0]}] <= mem_dq_o;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R7 bus monitor
  always @(negedge clk) begin
    if (rst_n && !done && !mem_oe_n && mem_dq_oe) begin
      n_bad++;
      $display("FAIL R7 contention act=%h exp=%h", {mem_oe_n, mem_dq_oe}, 2'b10);
    end
  end

  task automatic chk_sel(input logic [16:0] a, input string tag);
    logic [3:0] act, exp;
    act = {mem_ce_a_n, mem_ce_b_n, mem_a15_a, mem_a15_b};
    exp = {a[16], !a[16], a[16] ? 1'b0 : a[15], a[16] ? a[15] : 1'b0};
    chk(act == exp, tag, 32'(act), 32'(exp));
    chk(mem_addr == a[14:0], "R10 addr", 32'(mem_addr), 32'(a[14:0]));
  endtask

  task automatic chk_quiet(input string tag);
    logic [5:0] act;
    act = {mem_ce_a_n, mem_ce_b_n, mem_we_n, mem_oe_n, mem_dq_oe, ack};
    chk(act == 6'b111100, tag, 32'(act), 32'h3C);
  endtask

  // Caller stands at a negedge; returns at the negedge of the ack cycle.
  task automatic do_write(input logic [16:0] a, input logic [15:0] d);
    req = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk_sel(a, a[16] ? "R3 wr setup sel" : "R2 wr setup sel");
    chk({mem_we_n, mem_oe_n, mem_dq_oe} == 3'b110, "R4 wr setup strobes",
        32'({mem_we_n, mem_oe_n, mem_dq_oe}), 32'h6);
    @(negedge clk);
    chk({mem_we_n, mem_oe_n, mem_dq_oe} == 3'b011, "R4 wr strobe",
        32'({mem_we_n, mem_oe_n, mem_dq_oe}), 32'h3);
    chk(mem_dq_o == d, "R11 wr data", 32'(mem_dq_o), 32'(d));
    chk_sel(a, "R10 wr strobe sel");
    @(negedge clk);
    chk(ack == 1'b1, "R6 wr ack", 32'(ack), 32'h1);
    chk({mem_we_n, mem_dq_oe} == 2'b10, "R4 wr release", 32'({mem_we_n, mem_dq_oe}), 32'h2);
  endtask

  // Caller stands at a negedge; returns at the negedge after turnaround.
  task automatic do_read(input logic [16:0] a, input logic [15:0] exp);
    req = 1'b1; req_wr = 1'b0; req_addr = a; req_wdata = 16'h0;
    @(negedge clk);
    req = 1'b0;
    chk_sel(a, a[16] ? "R3 rd setup sel" : "R2 rd setup sel");
    chk({mem_we_n, mem_oe_n} == 2'b11, "R5 rd setup oe", 32'({mem_we_n, mem_oe_n}), 32'h3);
    @(negedge clk);
    chk({mem_we_n, mem_oe_n, mem_dq_oe} == 3'b100, "R5 rd strobe",
        32'({mem_we_n, mem_oe_n, mem_dq_oe}), 32'h4);
    @(negedge clk);
    chk(ack == 1'b1, "R6 rd ack", 32'(ack), 32'h1);
    chk(rd_data == exp, "R5 rd data", 32'(rd_data), 32'(exp));
    chk({mem_ce_a_n, mem_ce_b_n} == 2'b11, "R8 turn ce", 32'({mem_ce_a_n, mem_ce_b_n}), 32'h3);
    @(negedge clk);
    chk(ack == 1'b0, "R6 ack single", 32'(ack), 32'h0);
    chk(rd_data == exp, "R5 rd hold", 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk_quiet("R1 in reset");
    chk({mem_a15_a, mem_a15_b} == 2'b00, "R1 upper low", 32'({mem_a15_a, mem_a15_b}), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_quiet("R1 after reset");
  endtask

  task automatic t_basic();
    @(negedge clk);
    do_write(17'h00012, 16'hA5A5);
    do_write(17'h10012, 16'h5A5A);            // R3 same low address, bank B
    do_write(17'h08034, 16'hFFFF);            // R2 upper line on bank A
    do_write(17'h18034, 16'h0000);            // R3 upper line on bank B
    do_write(17'h07F56, 16'h1234);            // R10 high address bits
    @(negedge clk);
    chk_quiet("R4 idle after writes");
    do_read(17'h00012, 16'hA5A5);
    do_read(17'h10012, 16'h5A5A);             // R3 bank isolation
    do_read(17'h08034, 16'hFFFF);
    do_read(17'h18034, 16'h0000);
    do_read(17'h07F56, 16'h1234);
  endtask

  task automatic t_busy_ignored();
    // R9: intruding request held through a write
    req = 1'b1; req_wr = 1'b1; req_addr = 17'h00077; req_wdata = 16'hC3C3;
    @(negedge clk);
    req = 1'b1; req_addr = 17'h10088; req_wdata = 16'hDEAD;
    @(negedge clk);
    chk(!mem_ce_a_n && mem_ce_b_n, "R9 busy keeps bank", 32'({mem_ce_a_n, mem_ce_b_n}), 32'h1);
    @(negedge clk);
    chk(ack == 1'b1, "R9 ack", 32'(ack), 32'h1);
    req = 1'b0;
    @(negedge clk);
    chk_quiet("R9 no extra access");
    do_read(17'h10088, 16'h0000);
    do_read(17'h00077, 16'hC3C3);
  endtask

  task automatic t_turnaround();
    // R8: request raised in read ack cycle waits out turnaround
    req = 1'b1; req_wr = 1'b0; req_addr = 17'h00012; req_wdata = '0;
    @(negedge clk);
    req = 1'b0;
    repeat (2) @(negedge clk);
    chk(ack && rd_data == 16'hA5A5, "R8 read done", 32'(rd_data), 32'hA5A5);
    req = 1'b1; req_wr = 1'b1; req_addr = 17'h100AB; req_wdata = 16'h0F0F;
    @(negedge clk);
    chk({mem_ce_a_n, mem_ce_b_n, ack} == 3'b110, "R8 turnaround idle",
        32'({mem_ce_a_n, mem_ce_b_n, ack}), 32'h6);
    @(negedge clk);
    req = 1'b0;
    chk_sel(17'h100AB, "R8 accepted after turn");
    @(negedge clk);
    chk(!mem_we_n && mem_dq_o == 16'h0F0F, "R8 write strobe", 32'(mem_dq_o), 32'h0F0F);
    @(negedge clk);
    chk(ack == 1'b1, "R8 write ack", 32'(ack), 32'h1);
    // R8: after a write, next request accepted immediately
    do_write(17'h000CD, 16'h8001);
    do_read(17'h100AB, 16'h0F0F);
    do_read(17'h000CD, 16'h8001);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    for (int i = 0; i < 512; i++) begin
      bank_a[i] = '0;
      bank_b[i] = '0;
    end
    t_reset();
    t_basic();
    t_busy_ignored();
    t_turnaround();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule